// File: doc/BRIEF.md
# Clock-Run Handshake Agent

This block sits on the device side of a shared, active-low, open-drain clock-run line. The host uses that line to announce its intent. While the line is held low, the bus clock is running normally or is about to start. When the host lets the line float high, it means the clock is about to be stopped or slowed to a rate too low for operation. The device never drives the line high. It either pulls the line low or releases it. It pulls low for one of two reasons: to keep a running clock from being halted, or to ask for a clock that has already stopped to be brought back.

The agent watches the line through a synchroniser. If the host releases the line while the device has work pending, the agent vetoes the stop with a short low pulse. If no work is pending, the agent lets the clock stop. When work then arrives with the clock stopped, the agent pulls the line low at once, with no clock edge needed. It keeps pulling until it sees the line low on a running clock edge, and then adds a short hold. A disable input makes the agent claim the clock permanently, including while it is idle.

Top module: `clkrun_agent`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with the line low, `pull_oe` is 0. The line synchroniser resets to the value that means "line low".
- R2: Encodings are as follows. `line_in`=1 means the line is high (stop requested). `pull_oe`=1 means the device pulls the line low. If `line_in` goes high while `act_req` is 1, `pull_oe` rises after the third rising clock edge: two edges through the synchroniser, plus one for the state register.
- R3: A veto pulse, or the hold that follows a restore, keeps `pull_oe` at 1 for exactly HOLD_CYCLES (2) clock periods, after which `pull_oe` returns to 0.
- R4: Suppose the line has been sampled high with `act_req` at 0, so the clock may stop. A later rise of `act_req` then sets `pull_oe` to 1 with no clock edge. `pull_oe` stays at 1 until the line has been sampled low on running edges, then stays for HOLD_CYCLES more edges.
- R5: While `feat_dis` is 1, `pull_oe` is 1 from the next clock edge onward, whatever `act_req` is. After `feat_dis` returns to 0, `pull_oe` is 0 from the next edge, provided the line is low.
- R6: While the line stays low, `act_req` has no effect: `pull_oe` stays 0.
- R7: A stop request made while `act_req` is 0 is not vetoed: `pull_oe` stays 0.
- R8: In a system with a host that honours vetoes, the bus clock is never gated off while `act_req` is 1, and a stopped clock is restarted once activity appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; may be stopped by the host |
| rst_n | input | 1 | Active-low reset, asynchronous |
| line_in | input | 1 | Raw level of the shared line (1 = high) |
| act_req | input | 1 | Device activity pending (DMA or incoming traffic) |
| feat_dis | input | 1 | 1 disables clock-run: claim the clock permanently |
| pull_oe | output | 1 | Open-drain enable; 1 pulls the line low |

## Verification
The bench models the host's pull-up, its decision to stop the clock, and glitch-free gating of the clock. It then probes the exact edge on which the veto pulse starts and ends. A design that skipped synchroniser stages, or stretched or shortened the hold, would be caught on that count.

The restore case raises activity while the clock is stopped and checks the output before any edge arrives. A design that waited for a clock edge would deadlock there, because the host would never restart the clock. Other checks cover the idle stop, activity on a low line, and both directions of the disable input. These catch a device that vetoes without cause, or that fails to hold the clock when disabled.

// File: rtl/clkrun_agent.sv
module clkrun_agent #(
  parameter int HOLD_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic act_req,
  input  logic feat_dis,
  output logic pull_oe
);
  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  typedef enum logic [1:0] {IDLE_MONITOR, HOLD_CLOCK, RESTORE_REQ, DISABLED_CLAIM} st_t;

  st_t st, st_nx;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic line_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};

  assign line_hi = sync_q[SYNC_STAGES-1];

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt_q;
    if (feat_dis) st_nx = DISABLED_CLAIM;
    else
      case (st)
        IDLE_MONITOR:
          if (line_hi) begin
            if (act_req) begin st_nx = HOLD_CLOCK; cnt_nx = LAST; end
            else st_nx = RESTORE_REQ;
          end
        HOLD_CLOCK:
          if (cnt_q == '0) st_nx = IDLE_MONITOR;
          else cnt_nx = cnt_q - CW'(1);
        RESTORE_REQ:
          if (!line_hi) begin
            if (act_req) begin st_nx = HOLD_CLOCK; cnt_nx = LAST; end
            else st_nx = IDLE_MONITOR;
          end
        DISABLED_CLAIM: st_nx = IDLE_MONITOR;
        default: st_nx = IDLE_MONITOR;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= IDLE_MONITOR;
      cnt_q <= '0;
    end else begin
      st    <= st_nx;
      cnt_q <= cnt_nx;
    end

  // restore request is combinational in act_req: works with the clock stopped
  assign pull_oe = (st == HOLD_CLOCK) || (st == DISABLED_CLAIM) ||
                   ((st == RESTORE_REQ) && act_req);

  p_veto_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE_MONITOR && line_hi && act_req && !feat_dis) |=> pull_oe);

  p_hold_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pull_oe) && st == HOLD_CLOCK) |=> pull_oe);

  p_hold_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD_CLOCK && cnt_q == '0 && !feat_dis) |=> !pull_oe);

  p_restore_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RESTORE_REQ && act_req && line_hi && !feat_dis) |=> pull_oe);

  p_dis_claim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    feat_dis |=> pull_oe);

  p_quiet_low_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE_MONITOR && !line_hi && !feat_dis) |=> !pull_oe);
endmodule

// File: tb/test_clkrun_agent.sv
module test_clkrun_agent;
  logic clk_free = 1'b0, clk_en = 1'b1;
  logic rst_n = 1'b0, host_low = 1'b1, act_req = 1'b0, feat_dis = 1'b0;
  logic clk, line, pull_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_free = ~clk_free;
  assign clk  = clk_free & clk_en;
  assign line = (host_low || pull_oe) ? 1'b0 : 1'b1;

  clkrun_agent i_clkrun_agent (.clk(clk), .rst_n(rst_n), .line_in(line),
    .act_req(act_req), .feat_dis(feat_dis), .pull_oe(pull_oe));

  task automatic chk(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_free);
    chk("R1", pull_oe, 1'b0, "in reset");
    rst_n = 1'b1;
    @(negedge clk_free);
    chk("R1", pull_oe, 1'b0, "after reset");
  endtask

  task automatic t_low_line_r6();
    host_low = 1'b1;
    for (int i = 0; i < 8; i++) begin
      act_req = i[0];
      @(negedge clk_free);
      chk("R6", pull_oe, 1'b0, "activity on low line");
    end
  endtask

  task automatic t_veto();
    bit vetoed = 0;
    act_req = 1'b1;
    @(negedge clk_free);
    host_low = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk_free);
      if (i <= 5) chk((i == 3) ? "R2" : "R3", pull_oe, (i == 3 || i == 4), $sformatf("veto edge %0d", i));
      if (line == 1'b0 && !vetoed) begin vetoed = 1; host_low = 1'b1; end
    end
    chk("R8", vetoed, 1'b1, "host saw veto");
    chk("R8", clk_en, 1'b1, "clock kept running");
  endtask

  task automatic t_idle_stop_restore();
    act_req = 1'b0;
    @(negedge clk_free);
    host_low = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk_free);
      chk("R7", pull_oe, 1'b0, $sformatf("idle stop edge %0d", i));
      if (line == 1'b0) host_low = 1'b1;
    end
    chk("R8", act_req, 1'b0, "no activity when stopping");
    if (line == 1'b1) clk_en = 1'b0;
    chk("R7", clk_en, 1'b0, "clock stopped when idle");
    repeat (5) @(negedge clk_free);
    chk("R4", pull_oe, 1'b0, "stopped and idle");
    #1 act_req = 1'b1;
    #1 chk("R4", pull_oe, 1'b1, "async restore with clock off");
    @(negedge clk_free);
    if (line == 1'b0) begin clk_en = 1'b1; host_low = 1'b1; end
    chk("R8", clk_en, 1'b1, "clock restarted");
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk_free);
      chk((i == 5) ? "R3" : "R4", pull_oe, (i <= 4), $sformatf("restore edge %0d", i));
    end
  endtask

  task automatic t_disabled();
    bit vetoed = 0;
    act_req = 1'b0;
    feat_dis = 1'b1;
    @(negedge clk_free);
    chk("R5", pull_oe, 1'b1, "claim after disable");
    host_low = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk_free);
      chk("R5", pull_oe, 1'b1, $sformatf("disabled claim edge %0d", i));
      if (line == 1'b0 && !vetoed) begin vetoed = 1; host_low = 1'b1; end
    end
    chk("R5", clk_en, 1'b1, "clock held while disabled idle");
    feat_dis = 1'b0;
    @(negedge clk_free);
    chk("R5", pull_oe, 1'b0, "release after enable");
    repeat (3) @(negedge clk_free);
    chk("R5", pull_oe, 1'b0, "stays released");
  endtask

  initial begin
    t_reset();
    t_low_line_r6();
    t_veto();
    t_idle_stop_restore();
    t_disabled();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_free);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule